// File: doc/BRIEF.md
# Multiprocessor-format UART status logic

This block is an asynchronous serial transmitter and receiver with a small register port. Software writes a byte into a transmit holding register, and the transmitter moves it into its shift register as soon as it is idle. An empty flag tells software when the holding register can take the next byte. A transmit-end flag tells software when the line has gone quiet, meaning the last stop bit has left and nothing is queued. In multiprocessor format each frame carries one extra bit after the data byte, which marks the frame as an address or as data. Software picks the outgoing value through a status control bit. The receiver keeps the incoming value in a read-only status bit.

The baud rate comes in from outside as a one-cycle tick. Each bit lasts `OVS` ticks. The receiver samples each bit at its middle. A clocked-synchronous mode bit only suppresses the extra bit; it does not change the rest of the frame.

Both directions are controlled by a frame state machine with the states `F_IDLE`, `F_START`, `F_DATA`, `F_MPB` and `F_STOP`.
- Transmitter transitions:
  - It goes from idle to start when a byte is pending.
  - It goes from start to data after one bit time.
  - It goes from data to the extra-bit state or to stop after the eighth data bit.
  - It goes from the extra-bit state to stop after one bit time.
  - From stop, it goes straight back to start if another byte is pending, or to idle otherwise.
- Receiver transitions:
  - It goes from idle to start on a low line at a tick.
  - It goes from start back to idle if the line is high again at the middle of the start bit, or on to data if it is still low.
  - The data, extra-bit and stop states follow in the same order as in the transmitter.
  - It returns from stop to idle after sampling the stop bit.
- Clearing the matching enable bit sends either machine to idle from any state.

Top module: `uart_mp_core`

## Requirements
- R1: After reset the status register (address 3) reads 0x09, the TX line is high, and the receive register (address 1) reads 0x00. In the status register, bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is framing error, bit 3 is transmit-end, bit 4 is the received multiprocessor bit and bit 5 is the outgoing multiprocessor bit.
- R2: A frame consists of a low start bit, then 8 data bits LSB first, then the outgoing multiprocessor bit when the frame carries one, then a high stop bit. Each bit lasts 16 ticks. A frame carries the extra bit only when control bit 2 (multiprocessor enable) is 1 and control bit 3 (synchronous mode) is 0. The control register is at address 2; bit 0 is transmit enable and bit 1 is receive enable.
- R3: Writing the transmit register (address 0) while transmit is enabled clears transmit-end and transmit-empty. Transmit-end stays 0 for the whole frame and sets once the stop bit ends with transmit-empty at 1.
- R4: If a byte is written while a frame is in flight, it starts right after that frame's stop bit, and transmit-end stays 0 between the two frames.
- R5: While transmit enable is 0, transmit-end and transmit-empty read 1 and the line is idle high.
- R6: Writing 0 to transmit-empty, receive-full or framing error clears that flag only if the previous status access was a read that saw the flag at 1. Clearing transmit-empty this way also clears transmit-end and sends the current holding register contents.
- R7: Writes to status bits 3 and 4 have no effect.
- R8: A received frame that carries the extra bit stores that bit in status bit 4. A frame without the extra bit leaves status bit 4 unchanged.
- R9: While receive enable is 0 no frame is received, and status bit 4 keeps its value.
- R10: Status bit 5 is sent as the extra bit. It has no effect when multiprocessor enable is 0 or synchronous mode is 1, because the frame then has no extra bit.
- R11: The receiver samples at mid-bit, so a low pulse shorter than half a bit is not taken as a start bit. A low stop bit sets the framing-error flag and still loads the receive register and sets receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to arm clears) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
If the transmitter's state or bit counter goes wrong, the fault shows up in how long transmit-end stays 0. A frame that is one bit too long or too short moves the rising edge by 16 ticks, so each send is timed against a narrow window. If the received-bit latch is corrupted or updated at the wrong time, the fault shows on status bit 4 right after the next frame, including frames sent while reception is off. A wrong arm state shows up one write later: a flag either clears when it should not, or stays set when it should clear.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
    localparam int DW = 8;

    localparam logic [1:0] A_TXD  = 2'd0;
    localparam logic [1:0] A_RXD  = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int S_TXE  = 0;
    localparam int S_RXF  = 1;
    localparam int S_FERR = 2;
    localparam int S_TEND = 3;
    localparam int S_MPRX = 4;
    localparam int S_MPTX = 5;

    localparam int C_TXON = 0;
    localparam int C_RXON = 1;
    localparam int C_MPEN = 2;
    localparam int C_SYNC = 3;
    localparam int CTRL_W = 4;

    typedef enum logic [2:0] {
        F_IDLE,
        F_START,
        F_DATA,
        F_MPB,
        F_STOP
    } frame_st_e;
endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
    import uart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          mp_frame,
    input  logic          mp_bit,
    input  logic          pend,
    input  logic [DW-1:0] hold,
    output logic          load,
    output logic          done,
    output logic          idle,
    output logic          txd
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    frame_st_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] sh_q;
    logic          mpb_q, mpf_q;
    logic          bit_end;

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        done = 1'b0;
        unique case (st_q)
            F_IDLE:  if (pend) begin st_d = F_START; load = 1'b1; end
            F_START: if (bit_end) st_d = F_DATA;
            F_DATA:  if (bit_end && idx_q == IW'(DW - 1)) st_d = mpf_q ? F_MPB : F_STOP;
            F_MPB:   if (bit_end) st_d = F_STOP;
            F_STOP:  if (bit_end) begin
                         if (pend) begin st_d = F_START; load = 1'b1; end
                         else      begin st_d = F_IDLE;  done = 1'b1; end
                     end
            default: st_d = F_IDLE;
        endcase
        if (!en) begin
            st_d = F_IDLE;
            load = 1'b0;
            done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            mpb_q <= 1'b0;
            mpf_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= hold;
            mpb_q <= mp_bit;
            mpf_q <= mp_frame;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            if (bit_end && st_q == F_DATA) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            F_START: txd = 1'b0;
            F_DATA:  txd = sh_q[0];
            F_MPB:   txd = mpb_q;
            default: txd = 1'b1;
        endcase
    end

    assign idle = (st_q == F_IDLE);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
    import uart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          mp_frame,
    input  logic          rxd,
    output logic          done,
    output logic          fe,
    output logic          mpv,
    output logic          mpb,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);

    frame_st_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] sh_q;
    logic          mpb_q, mpf_q;
    logic          bit_end, mid_start;

    assign bit_end   = tick && (cnt_q == CW'(OVS - 1));
    assign mid_start = tick && (st_q == F_START) && (cnt_q == HALF_M1);

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q)
            F_IDLE:  if (tick && !rxd) st_d = F_START;
            F_START: if (mid_start) st_d = rxd ? F_IDLE : F_DATA;
            F_DATA:  if (bit_end && idx_q == IW'(DW - 1)) st_d = mpf_q ? F_MPB : F_STOP;
            F_MPB:   if (bit_end) st_d = F_STOP;
            F_STOP:  if (bit_end) begin st_d = F_IDLE; done = 1'b1; end
            default: st_d = F_IDLE;
        endcase
        if (!en) begin
            st_d = F_IDLE;
            done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            mpb_q <= 1'b0;
            mpf_q <= 1'b0;
        end else if (st_q == F_IDLE) begin
            cnt_q <= '0;
            idx_q <= '0;
            mpf_q <= mp_frame;
        end else if (tick) begin
            cnt_q <= (mid_start || bit_end) ? '0 : cnt_q + 1'b1;
            if (bit_end && st_q == F_DATA) begin
                sh_q  <= {rxd, sh_q[DW-1:1]};
                idx_q <= idx_q + 1'b1;
            end
            if (bit_end && st_q == F_MPB) mpb_q <= rxd;
        end
    end

    assign fe   = !rxd;
    assign mpv  = mpf_q;
    assign mpb  = mpb_q;
    assign data = sh_q;
endmodule

// File: rtl/uart_mp_core.sv
module uart_mp_core
    import uart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          txd_o,
    input  logic          rxd_i
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     hold_q, rxbuf_q;
    logic              txe_q, tend_q, rxf_q, ferr_q, mprx_q, mptx_q;
    logic [2:0]        arm_q;
    logic [1:0]        rsync_q;

    logic wr_txd, wr_stat, wr_ctrl, rd_stat;
    logic tx_on, rx_on, mp_frame;
    logic tx_load, tx_done, tx_idle;
    logic rx_done, rx_fe, rx_mpv, rx_mpb;
    logic [DW-1:0] rx_data;

    assign wr_txd  = reg_wr && (reg_addr == A_TXD);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign rd_stat = reg_rd && (reg_addr == A_STAT);

    assign tx_on    = ctrl_q[C_TXON];
    assign rx_on    = ctrl_q[C_RXON];
    assign mp_frame = ctrl_q[C_MPEN] && !ctrl_q[C_SYNC];

    uart_mp_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_on),
        .mp_frame(mp_frame), .mp_bit(mptx_q), .pend(!txe_q), .hold(hold_q),
        .load(tx_load), .done(tx_done), .idle(tx_idle), .txd(txd_o)
    );

    uart_mp_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_on),
        .mp_frame(mp_frame), .rxd(rsync_q[1]),
        .done(rx_done), .fe(rx_fe), .mpv(rx_mpv), .mpb(rx_mpb), .data(rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            hold_q  <= '0;
            rsync_q <= 2'b11;
        end else begin
            rsync_q <= {rsync_q[0], rxd_i};
            if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (wr_txd)  hold_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_q   <= 1'b1;
            tend_q  <= 1'b1;
            rxf_q   <= 1'b0;
            ferr_q  <= 1'b0;
            mprx_q  <= 1'b0;
            mptx_q  <= 1'b0;
            arm_q   <= '0;
            rxbuf_q <= '0;
        end else begin
            if (rd_stat)      arm_q <= {ferr_q, rxf_q, txe_q};
            else if (wr_stat) arm_q <= '0;
            if (wr_stat) mptx_q <= reg_wdata[S_MPTX];

            if (!tx_on) begin
                txe_q  <= 1'b1;
                tend_q <= 1'b1;
            end else begin
                if (tx_load) txe_q  <= 1'b1;
                if (tx_done) tend_q <= 1'b1;
                if (wr_txd || (wr_stat && arm_q[0] && !reg_wdata[S_TXE])) begin
                    txe_q  <= 1'b0;
                    tend_q <= 1'b0;
                end
            end

            if (wr_stat && arm_q[1] && !reg_wdata[S_RXF])  rxf_q  <= 1'b0;
            if (wr_stat && arm_q[2] && !reg_wdata[S_FERR]) ferr_q <= 1'b0;
            if (rx_done) begin
                rxf_q   <= 1'b1;
                rxbuf_q <= rx_data;
                if (rx_fe)  ferr_q <= 1'b1;
                if (rx_mpv) mprx_q <= rx_mpb;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_TXD:   reg_rdata = hold_q;
            A_RXD:   reg_rdata = rxbuf_q;
            A_CTRL:  reg_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            default: reg_rdata = {2'b00, mptx_q, mprx_q, tend_q, ferr_q, rxf_q, txe_q};
        endcase
    end
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_on,
    input logic tend,
    input logic txe,
    input logic txd,
    input logic tx_idle,
    input logic rx_done,
    input logic mprx,
    input logic wr_txd
);
    AST_OFF_FORCES_END: assert property (@(posedge clk) disable iff (!rst_n) !tx_on |=> (tend && txe)); // R5
    AST_WRITE_CLEARS_END: assert property (@(posedge clk) disable iff (!rst_n) (wr_txd && tx_on) |=> (!tend && !txe)); // R3
    AST_END_RISE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tend) |-> txe); // R3
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) tx_idle |-> txd); // R2
    AST_MPRX_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_done |=> $stable(mprx)); // R9
endmodule

bind uart_mp_core uart_mp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .tend(tend_q), .txe(txe_q),
    .txd(txd_o), .tx_idle(tx_idle), .rx_done(rx_done), .mprx(mprx_q), .wr_txd(wr_txd)
);

// File: tb/uart_mp_core_bench.sv
module uart_mp_core_bench;
    localparam int LIMIT = 150000;
    localparam int BT = 64; // clocks per bit: 16 ticks x 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic [1:0] tdiv = '0;
    logic [1:0] reg_addr = 2'd3;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic txd;
    logic loop_en = 1'b1, drv = 1'b1;
    logic rx_line;
    int cyc = 0, n_chk = 0, n_bad = 0;

    assign rx_line = loop_en ? txd : drv;

    uart_mp_core u_uart_mp_core (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .txd_o(txd), .rxd_i(rx_line)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tdiv <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
        if (cyc == LIMIT) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd3;
    endtask

    task automatic wait_end(input int t0, output int dur);
        logic [7:0] s;
        dur = -1;
        for (int i = 0; i < 4000; i++) begin
            peek(2'd3, s);
            if (s[3]) begin dur = cyc - t0; break; end
        end
    endtask

    task automatic send(input logic [7:0] d, output int dur);
        int t0;
        wr(2'd0, d);
        t0 = cyc;
        wait_end(t0, dur);
    endtask

    task automatic clear_rx();
        logic [7:0] s;
        rd(2'd3, s);
        wr(2'd3, 8'h01 | (s & 8'h20));
    endtask

    task automatic hold_line(input logic v, input int ticks);
        drv = v;
        repeat (ticks) @(posedge baud_tick);
    endtask

    // {sync, mp_en, mp_bit, data}
    localparam logic [10:0] VECS [6] = '{
        {1'b0, 1'b1, 1'b1, 8'h55},
        {1'b0, 1'b1, 1'b0, 8'hA3},
        {1'b0, 1'b0, 1'b1, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'hFF},
        {1'b1, 1'b1, 1'b1, 8'h81},
        {1'b0, 1'b1, 1'b0, 8'h3C}
    };

    initial begin
        logic [7:0] s, d;
        int dur, nb, t0;
        logic exp_mprx;
        exp_mprx = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd3, s); chk("R1 status after reset", s, 8'h09);
        peek(2'd1, d); chk("R1 receive reg after reset", d, 8'h00);
        chk("R1 line idle", txd, 1);

        // Vector loop: R2 frame length, R8 capture, R10 gating, R3 end flag
        foreach (VECS[i]) begin
            logic sy, mp, mb;
            logic [7:0] dv;
            {sy, mp, mb, dv} = VECS[i];
            wr(2'd2, {4'b0, sy, mp, 2'b11});
            wr(2'd3, {2'b00, mb, 5'b00111});
            wr(2'd0, dv);
            t0 = cyc;
            peek(2'd3, s); chk("R3 end flag clears on write", s[3], 0);
            wait_end(t0, dur);
            nb = (mp && !sy) ? 11 : 10;
            chk_rng("R2 R10 frame duration", dur, nb * BT - 8, nb * BT + 12);
            if (mp && !sy) exp_mprx = mb;
            peek(2'd1, d); chk("R2 loopback data", d, dv);
            peek(2'd3, s);
            chk("R8 received mp bit", s[4], exp_mprx);
            chk("R2 receive full", s[1], 1);
            chk("R11 no framing error", s[2], 0);
            clear_rx();
            peek(2'd3, s); chk("R6 receive-full cleared", s[1], 0);
        end

        // R7 read-only bits: try to write tend=0 and mprx=1
        wr(2'd3, 8'h17);
        peek(2'd3, s);
        chk("R7 tend unchanged", s[3], 1);
        chk("R7 mprx unchanged", s[4], exp_mprx);

        // R6 write-0 without prior read has no effect
        wr(2'd3, 8'h06);
        peek(2'd3, s);
        chk("R6 unarmed txe", s[0], 1);
        chk("R6 unarmed tend", s[3], 1);
        // R6 armed clear resends holding register
        rd(2'd3, s);
        wr(2'd3, 8'h06);
        t0 = cyc;
        peek(2'd3, s); chk("R6 armed clear drops tend", s[3], 0);
        wait_end(t0, dur);
        chk_rng("R6 resend duration", dur, 11 * BT - 8, 11 * BT + 12);
        peek(2'd1, d); chk("R6 holding byte resent", d, 8'h3C);
        clear_rx();

        // R4 queued byte
        wr(2'd0, 8'hC4);
        t0 = cyc;
        for (int i = 0; i < 20; i++) begin
            peek(2'd3, s);
            if (s[0]) break;
        end
        wr(2'd0, 8'h2B);
        while (cyc < t0 + 11 * BT + 20) @(negedge clk);
        peek(2'd3, s); chk("R4 tend low between frames", s[3], 0);
        wait_end(t0, dur);
        chk_rng("R4 back-to-back duration", dur, 22 * BT - 8, 22 * BT + 12);
        peek(2'd1, d); chk("R4 second byte received", d, 8'h2B);
        clear_rx();

        // R9 receive disable holds mprx
        wr(2'd2, 8'h07);
        wr(2'd3, 8'h27);
        send(8'h5A, dur);
        peek(2'd3, s); chk("R8 mp bit one captured", s[4], 1);
        clear_rx();
        wr(2'd2, 8'h05);
        wr(2'd3, 8'h07);
        send(8'h11, dur);
        peek(2'd3, s);
        chk("R9 mprx held with receive off", s[4], 1);
        chk("R9 no reception while off", s[1], 0);

        // R5 transmit disable forces flags
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h77);
        peek(2'd3, s); chk("R3 tend low in frame", s[3], 0);
        wr(2'd2, 8'h00);
        peek(2'd3, s);
        chk("R5 tend forced", s[3], 1);
        chk("R5 txe forced", s[0], 1);
        chk("R5 line high", txd, 1);

        // R11 receiver qualification and framing error
        loop_en = 1'b0;
        wr(2'd2, 8'h02);
        hold_line(1'b0, 4);
        hold_line(1'b1, 40);
        peek(2'd3, s); chk("R11 short glitch ignored", s[1], 0);
        hold_line(1'b0, 16);
        for (int b = 0; b < 8; b++) hold_line(((8'h96 >> b) & 1) != 0, 16);
        hold_line(1'b0, 10);
        hold_line(1'b1, 30);
        peek(2'd3, s);
        chk("R11 full on bad stop", s[1], 1);
        chk("R11 framing error", s[2], 1);
        peek(2'd1, d); chk("R11 data still loaded", d, 8'h96);
        rd(2'd3, s);
        wr(2'd3, 8'h01);
        peek(2'd3, s); chk("R6 framing error cleared", s[2], 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule